// File: doc/BRIEF.md
# NAND Flash Opcode-List Sequencer

This block carries out one NAND flash transaction, described by a short list of micro-operations that software loads before pulsing `start`. The list holds eight 4-bit slots. The block runs them from slot 0 upward. Each slot can do one of these things: issue a command byte, send the column or the row address, wait for the ready line, move a run of data bytes between the flash and a local page buffer, or read a status byte. The block drives the 8-bit flash bus strobes itself and watches the ready/busy line through a synchronizer. At the end of the list it raises either a completion flag or a timeout flag.

The page buffer sits outside the block. It is reached through a byte port with one clock of read latency. The buffer is divided into 1 KB slots, and the page number picks the slot. Two page formats are supported: 2048-byte pages with a 64-byte spare area, and 512-byte pages with a 16-byte spare area.

Top module: `nand_opseq`

## Requirements
- R1: Opcode slot k occupies `instr_word[4k+3:4k]`, and slots execute in order from slot 0. Code 0, or any code from 12 to 15, ends the list. The list also ends after slot 7 has run.
- R2: Codes 1 to 4 each send one byte with CLE high and one WE# pulse. Code n sends `cmd_word[8(n-1)+7 : 8(n-1)]`.
- R3: Code 5 sends the column with ALE high. Large pages take two bytes: `col_addr[7:0]`, then the upper column bits. Small pages take one byte: `col_addr[7:0]`.
- R4: Code 6 sends three ALE bytes, low byte first, of the row number. The row number is `{blk_num, page_idx[5:0]}` for large pages and `{blk_num, page_idx[4:0]}` for small pages.
- R5: Data transfers start at buffer address `1024*slot + col_addr`, plus the main-area size (2048 or 512) when `spare_sel` is set. The slot is `4*page_idx[0]` for large pages and `page_idx[2:0]` for small pages. Each later byte goes to the next address, and the address keeps counting across transfer opcodes.
- R6: Code 7 waits until the ready line shows ready, then reads bytes with RE# pulses into the buffer. No RE# pulse occurs while the flash is busy. Code 8 sends bytes read from the buffer with WE# pulses, with neither CLE nor ALE high.
- R7: A `byte_cnt` of 0 moves one full page plus its spare area (2112 bytes for large pages, 528 for small pages). Any other value moves exactly that many bytes.
- R8: Code 9 waits for ready. Code 10 reads one byte with an RE# pulse into the data register shown on `dreg_out`.
- R9: Code 11 sends the data register byte as a single ALE cycle. The data register is loaded from `dreg_in` when `dreg_load` is high while the block is idle.
- R10: A list that finishes sets `done_ok`. If the ready line is still busy after `wait_limit` clocks of waiting, the block sets `tmo_err` instead and runs no further slots. The two flags are never high together, and both clear on the next accepted start.
- R11: Each bus cycle holds WE# or RE# low for `T_LO` clocks and then high for at least `T_HI` clocks.
- R12: CE# is low for the whole sequence and high when the block is idle. No strobe pulses while CE# is high. A start that arrives while the block is busy is ignored.
- R13: CLE and ALE are never high together, and WE# and RE# are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, honoured only when idle |
| instr_word | input | 32 | Eight 4-bit opcode slots |
| cmd_word | input | 32 | Four command bytes |
| large_page | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| blk_num | input | 16 | Block number |
| page_idx | input | 6 | Page index within the block |
| col_addr | input | 12 | Column address |
| spare_sel | input | 1 | Data transfers target the spare area |
| byte_cnt | input | 12 | Transfer length, 0 = page plus spare |
| wait_limit | input | 16 | Ready-wait limit in clocks |
| dreg_load | input | 1 | Load data register when idle |
| dreg_in | input | 8 | Data register load value |
| dreg_out | output | 8 | Data register contents |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | Last sequence completed |
| tmo_err | output | 1 | Last sequence timed out |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus data driven to flash |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_in | input | 8 | Bus data from flash |
| nf_rb_n | input | 1 | Ready (1) / busy (0) |
| buf_addr | output | 13 | Page buffer byte address |
| buf_re | output | 1 | Page buffer read request |
| buf_we | output | 1 | Page buffer write strobe |
| buf_wdata | output | 8 | Page buffer write data |
| buf_rdata | input | 8 | Page buffer read data, one clock after buf_re |

## Verification
The bench targets these corner cases:

- **Buffer address arithmetic.** A large-page read to an odd page must land at slot 4 (offset 4096). A small-page spare write at a non-zero column must land at offset 3072+512+3. A wrong slot or a missing spare offset would put data in the wrong place.
- **Transfer length.** A zero byte count must produce exactly 2112 RE# pulses and leave the byte just past the run untouched. An off-by-one in the counter would leave it touched.
- **Ending the list.** A list that fills all eight slots must stop after slot 7 rather than wrap. A reserved opcode must end the list early.
- **Timeout.** A stuck-busy flash must raise only `tmo_err`, release CE#, and skip the slots that follow.
- **Start while busy.** A second start during a running list must not replay the command bytes.

// File: rtl/nand_opseq_pkg.sv
// Package: opcode codes, bus cycle kinds and sequencer states shared by
// the NAND opcode-list sequencer. Assumes 4-bit opcodes.
package nand_opseq_pkg;

    localparam logic [3:0] OPC_NOP  = 4'd0;
    localparam logic [3:0] OPC_CMD0 = 4'd1;
    localparam logic [3:0] OPC_CMD1 = 4'd2;
    localparam logic [3:0] OPC_CMD2 = 4'd3;
    localparam logic [3:0] OPC_CMD3 = 4'd4;
    localparam logic [3:0] OPC_COL  = 4'd5;
    localparam logic [3:0] OPC_ROW  = 4'd6;
    localparam logic [3:0] OPC_RDW  = 4'd7;
    localparam logic [3:0] OPC_WR   = 4'd8;
    localparam logic [3:0] OPC_WAIT = 4'd9;
    localparam logic [3:0] OPC_STAT = 4'd10;
    localparam logic [3:0] OPC_UADR = 4'd11;

    typedef enum logic [2:0] {
        BK_CMD, BK_ADR, BK_RD, BK_WR, BK_ST
    } bus_kind_e;

    typedef enum logic [1:0] {
        AS_COL, AS_ROW, AS_USR
    } adr_src_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_LAUNCH, S_CYC, S_GUARD,
        S_RBWAIT, S_BUFRD, S_BUFLAT, S_FINISH
    } seq_state_e;

endpackage

// File: rtl/nand_opseq_strobe.sv
// Bus strobe timer: on a go pulse, holds the strobe active (pin low) for
// T_LO clocks, then inactive for T_HI clocks. Flags the last low clock
// (data capture point) and the last high clock (cycle done).
// Assumes go is only raised while the timer is idle.
module nand_opseq_strobe #(
    parameter int T_LO = 2,
    parameter int T_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic strobe_act,
    output logic cap,
    output logic done
);
    localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int CW   = $clog2(TMAX + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;

    // Phase sequencing of one strobe pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (go) begin
                    ph  <= PH_LO;
                    cnt <= '0;
                end
                PH_LO: if (cnt == CW'(T_LO - 1)) begin
                    ph  <= PH_HI;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_HI: if (cnt == CW'(T_HI - 1)) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Decoded phase outputs.
    always_comb begin
        strobe_act = (ph == PH_LO);
        cap        = (ph == PH_LO) && (cnt == CW'(T_LO - 1));
        done       = (ph == PH_HI) && (cnt == CW'(T_HI - 1));
    end
endmodule

// File: rtl/nand_opseq_rbsync.sv
// Two-flop synchronizer for the flash ready/busy line.
// Assumes the line is asynchronous; resets to "ready".
module nand_opseq_rbsync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic rb_ready
);
    logic [1:0] sync_q;

    // Shift the raw line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rb_n_async};
    end

    assign rb_ready = sync_q[1];
endmodule

// File: rtl/nand_opseq_addr.sv
// Address former: builds the column and row byte strings, the start
// address inside the page buffer, and the transfer length.
// Assumes BLK_W + 6 <= ROW_BYTES*8 and ROW_BYTES <= 4.
module nand_opseq_addr #(
    parameter int BLK_W     = 16,
    parameter int COL_W     = 12,
    parameter int ROW_BYTES = 3,
    parameter int BUF_AW    = 13,
    parameter int SLOT_AW   = 10,
    parameter int CNT_W     = 12,
    parameter int MAIN_L    = 2048,
    parameter int SPARE_L   = 64,
    parameter int MAIN_S    = 512,
    parameter int SPARE_S   = 16
) (
    input  logic               large_page,
    input  logic [BLK_W-1:0]   blk_num,
    input  logic [5:0]         page_idx,
    input  logic [COL_W-1:0]   col_addr,
    input  logic               spare_sel,
    input  logic [CNT_W-1:0]   byte_cnt,
    output logic [15:0]        col_word,
    output logic [31:0]        row_word,
    output logic [BUF_AW-1:0]  buf_start,
    output logic [CNT_W-1:0]   xfer_len
);
    localparam int RW = ROW_BYTES * 8;

    logic [RW-1:0]     row_l, row_s;
    logic [2:0]        slot;
    logic [BUF_AW-1:0] base, spare_off;

    // Row number split: 6 index bits for large pages, 5 for small.
    always_comb begin
        row_l    = RW'({blk_num, page_idx});
        row_s    = RW'({blk_num, page_idx[4:0]});
        row_word = 32'(large_page ? row_l : row_s);
        col_word = 16'(col_addr);
    end

    // Buffer slot choice, spare offset and start address.
    always_comb begin
        slot      = large_page ? {page_idx[0], 2'b00} : page_idx[2:0];
        base      = BUF_AW'(slot) << SLOT_AW;
        spare_off = spare_sel ? (large_page ? BUF_AW'(MAIN_L) : BUF_AW'(MAIN_S)) : '0;
        buf_start = base + BUF_AW'(col_addr) + spare_off;
    end

    // Length: zero means main plus spare area.
    always_comb begin
        if (byte_cnt == '0)
            xfer_len = large_page ? CNT_W'(MAIN_L + SPARE_L) : CNT_W'(MAIN_S + SPARE_S);
        else
            xfer_len = byte_cnt;
    end
endmodule

// File: rtl/nand_opseq.sv
// NAND opcode-list sequencer top. Runs up to N_SLOTS software-loaded
// micro-ops on the flash bus, moving data to/from an external page buffer
// with one clock of read latency. Assumes the configuration inputs stay
// stable while busy is high.
module nand_opseq
    import nand_opseq_pkg::*;
#(
    parameter int N_SLOTS    = 8,
    parameter int OP_W       = 4,
    parameter int BLK_W      = 16,
    parameter int COL_W      = 12,
    parameter int ROW_BYTES  = 3,
    parameter int BUF_AW     = 13,
    parameter int CNT_W      = 12,
    parameter int WAIT_W     = 16,
    parameter int T_LO       = 2,
    parameter int T_HI       = 2,
    parameter int GUARD_CLKS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [N_SLOTS*OP_W-1:0]   instr_word,
    input  logic [31:0]               cmd_word,
    input  logic                      large_page,
    input  logic [BLK_W-1:0]          blk_num,
    input  logic [5:0]                page_idx,
    input  logic [COL_W-1:0]          col_addr,
    input  logic                      spare_sel,
    input  logic [CNT_W-1:0]          byte_cnt,
    input  logic [WAIT_W-1:0]         wait_limit,
    input  logic                      dreg_load,
    input  logic [7:0]                dreg_in,
    output logic [7:0]                dreg_out,
    output logic                      busy,
    output logic                      done_ok,
    output logic                      tmo_err,
    output logic                      nf_ce_n,
    output logic                      nf_cle,
    output logic                      nf_ale,
    output logic                      nf_we_n,
    output logic                      nf_re_n,
    output logic [7:0]                nf_dq_out,
    output logic                      nf_dq_oe,
    input  logic [7:0]                nf_dq_in,
    input  logic                      nf_rb_n,
    output logic [BUF_AW-1:0]         buf_addr,
    output logic                      buf_re,
    output logic                      buf_we,
    output logic [7:0]                buf_wdata,
    input  logic [7:0]                buf_rdata
);
    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam int GW     = $clog2(GUARD_CLKS + 1);

    seq_state_e        st;
    bus_kind_e         kind;
    adr_src_e          asrc;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        bidx, nb;
    logic [7:0]        out_byte, dreg;
    logic [CNT_W-1:0]  rem;
    logic [BUF_AW-1:0] ptr;
    logic [WAIT_W-1:0] tcnt;
    logic [GW-1:0]     gcnt;
    logic              wait_then_read, err_pend, busy_r, ok_r, tmo_r;

    logic [15:0]       col_word;
    logic [31:0]       row_word;
    logic [BUF_AW-1:0] buf_start;
    logic [CNT_W-1:0]  xfer_len;
    logic              rb_ready, strobe_act, cyc_cap, cyc_done, cyc_go;
    logic [OP_W-1:0]   op;
    logic [1:0]        cidx, bnext;
    logic              last_slot, in_cycle;
    logic [7:0]        next_adr_byte;

    nand_opseq_addr #(
        .BLK_W(BLK_W), .COL_W(COL_W), .ROW_BYTES(ROW_BYTES),
        .BUF_AW(BUF_AW), .CNT_W(CNT_W)
    ) u_addr (
        .large_page(large_page), .blk_num(blk_num), .page_idx(page_idx),
        .col_addr(col_addr), .spare_sel(spare_sel), .byte_cnt(byte_cnt),
        .col_word(col_word), .row_word(row_word),
        .buf_start(buf_start), .xfer_len(xfer_len)
    );

    nand_opseq_rbsync u_rbsync (
        .clk(clk), .rst_n(rst_n), .rb_n_async(nf_rb_n), .rb_ready(rb_ready)
    );

    nand_opseq_strobe #(.T_LO(T_LO), .T_HI(T_HI)) u_strobe (
        .clk(clk), .rst_n(rst_n), .go(cyc_go),
        .strobe_act(strobe_act), .cap(cyc_cap), .done(cyc_done)
    );

    // Slot decode helpers and next address byte selection.
    always_comb begin
        op        = instr_word[slot*OP_W +: OP_W];
        cidx      = 2'(op - OPC_CMD0);
        last_slot = (slot == SLOT_W'(N_SLOTS - 1));
        bnext     = bidx + 2'd1;
        case (asrc)
            AS_COL:  next_adr_byte = col_word[bnext[0]*8 +: 8];
            AS_ROW:  next_adr_byte = row_word[bnext*8 +: 8];
            default: next_adr_byte = dreg;
        endcase
    end

    // Main sequencer: slot fetch, bus cycles, ready waits, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;           kind <= BK_CMD;     asrc <= AS_COL;
            slot <= '0;             bidx <= '0;         nb <= '0;
            out_byte <= '0;         dreg <= '0;         rem <= '0;
            ptr <= '0;              tcnt <= '0;         gcnt <= '0;
            wait_then_read <= 1'b0; err_pend <= 1'b0;
            busy_r <= 1'b0;         ok_r <= 1'b0;       tmo_r <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        busy_r   <= 1'b1;
                        ok_r     <= 1'b0;
                        tmo_r    <= 1'b0;
                        err_pend <= 1'b0;
                        slot     <= '0;
                        ptr      <= buf_start;
                        st       <= S_FETCH;
                    end else if (dreg_load) begin
                        dreg <= dreg_in;
                    end
                end
                S_FETCH: begin
                    bidx <= '0;
                    case (op)
                        OPC_CMD0, OPC_CMD1, OPC_CMD2, OPC_CMD3: begin
                            kind     <= BK_CMD;
                            out_byte <= cmd_word[cidx*8 +: 8];
                            st       <= S_LAUNCH;
                        end
                        OPC_COL: begin
                            kind     <= BK_ADR;
                            asrc     <= AS_COL;
                            nb       <= large_page ? 2'd1 : 2'd0;
                            out_byte <= col_word[7:0];
                            st       <= S_LAUNCH;
                        end
                        OPC_ROW: begin
                            kind     <= BK_ADR;
                            asrc     <= AS_ROW;
                            nb       <= 2'(ROW_BYTES - 1);
                            out_byte <= row_word[7:0];
                            st       <= S_LAUNCH;
                        end
                        OPC_UADR: begin
                            kind     <= BK_ADR;
                            asrc     <= AS_USR;
                            nb       <= 2'd0;
                            out_byte <= dreg;
                            st       <= S_LAUNCH;
                        end
                        OPC_RDW, OPC_WAIT: begin
                            wait_then_read <= (op == OPC_RDW);
                            rem  <= xfer_len;
                            gcnt <= '0;
                            tcnt <= '0;
                            st   <= S_GUARD;
                        end
                        OPC_WR: begin
                            kind <= BK_WR;
                            rem  <= xfer_len;
                            st   <= S_BUFRD;
                        end
                        OPC_STAT: begin
                            kind <= BK_ST;
                            st   <= S_LAUNCH;
                        end
                        default: st <= S_FINISH;
                    endcase
                end
                S_GUARD: begin
                    if (gcnt == GW'(GUARD_CLKS - 1)) st <= S_RBWAIT;
                    else                             gcnt <= gcnt + 1'b1;
                end
                S_RBWAIT: begin
                    if (rb_ready) begin
                        if (wait_then_read) begin
                            kind <= BK_RD;
                            st   <= S_LAUNCH;
                        end else begin
                            slot <= slot + 1'b1;
                            st   <= last_slot ? S_FINISH : S_FETCH;
                        end
                    end else if (tcnt == wait_limit) begin
                        err_pend <= 1'b1;
                        st       <= S_FINISH;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                S_LAUNCH: st <= S_CYC;
                S_CYC: begin
                    if (cyc_cap && kind == BK_ST) dreg <= nf_dq_in;
                    if (cyc_cap && kind == BK_RD) ptr  <= ptr + 1'b1;
                    if (cyc_done) begin
                        case (kind)
                            BK_ADR: begin
                                if (bidx == nb) begin
                                    slot <= slot + 1'b1;
                                    st   <= last_slot ? S_FINISH : S_FETCH;
                                end else begin
                                    bidx     <= bnext;
                                    out_byte <= next_adr_byte;
                                    st       <= S_LAUNCH;
                                end
                            end
                            BK_RD: begin
                                rem <= rem - 1'b1;
                                if (rem == CNT_W'(1)) begin
                                    slot <= slot + 1'b1;
                                    st   <= last_slot ? S_FINISH : S_FETCH;
                                end else begin
                                    st <= S_LAUNCH;
                                end
                            end
                            BK_WR: begin
                                rem <= rem - 1'b1;
                                ptr <= ptr + 1'b1;
                                if (rem == CNT_W'(1)) begin
                                    slot <= slot + 1'b1;
                                    st   <= last_slot ? S_FINISH : S_FETCH;
                                end else begin
                                    st <= S_BUFRD;
                                end
                            end
                            default: begin
                                slot <= slot + 1'b1;
                                st   <= last_slot ? S_FINISH : S_FETCH;
                            end
                        endcase
                    end
                end
                S_BUFRD: st <= S_BUFLAT;
                S_BUFLAT: begin
                    out_byte <= buf_rdata;
                    st       <= S_LAUNCH;
                end
                S_FINISH: begin
                    busy_r <= 1'b0;
                    ok_r   <= !err_pend;
                    tmo_r  <= err_pend;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Flash bus pins driven from the cycle kind and strobe timer.
    always_comb begin
        in_cycle  = (st == S_LAUNCH) || (st == S_CYC);
        cyc_go    = (st == S_LAUNCH);
        nf_cle    = in_cycle && (kind == BK_CMD);
        nf_ale    = in_cycle && (kind == BK_ADR);
        nf_dq_oe  = in_cycle && (kind == BK_CMD || kind == BK_ADR || kind == BK_WR);
        nf_we_n   = !(strobe_act && (kind == BK_CMD || kind == BK_ADR || kind == BK_WR));
        nf_re_n   = !(strobe_act && (kind == BK_RD || kind == BK_ST));
        nf_dq_out = out_byte;
        nf_ce_n   = !busy_r;
    end

    // Page buffer port and status outputs.
    always_comb begin
        buf_addr  = ptr;
        buf_re    = (st == S_BUFRD);
        buf_we    = (st == S_CYC) && cyc_cap && (kind == BK_RD);
        buf_wdata = nf_dq_in;
        busy      = busy_r;
        done_ok   = ok_r;
        tmo_err   = tmo_r;
        dreg_out  = dreg;
    end
endmodule

// File: rtl/nand_opseq_chk.sv
// Protocol checker for nand_opseq, attached with bind. Watches pin-level
// relations and strobe width. Assumes synchronous active-low reset.
module nand_opseq_chk #(
    parameter int T_LO = 2
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done_ok,
    input logic tmo_err,
    input logic nf_ce_n,
    input logic nf_cle,
    input logic nf_ale,
    input logic nf_we_n,
    input logic nf_re_n,
    input logic buf_we
);
    logic [7:0] we_lo_cnt;

    // Count consecutive low clocks of WE#.
    always_ff @(posedge clk) begin
        if (!rst_n)        we_lo_cnt <= '0;
        else if (!nf_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
        else               we_lo_cnt <= '0;
    end

    AST_LATCH_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale)); // R13
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n)); // R13
    AST_STROBE_CE:   assert property (@(posedge clk) disable iff (!rst_n) nf_ce_n |-> (nf_we_n && nf_re_n)); // R12
    AST_FLAGS_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(done_ok && tmo_err)); // R10
    AST_FLAGS_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) (done_ok || tmo_err) |-> !busy); // R10
    AST_CAPTURE_RE:  assert property (@(posedge clk) disable iff (!rst_n) buf_we |-> !nf_re_n); // R6
    AST_WE_WIDTH:    assert property (@(posedge clk) disable iff (!rst_n) $rose(nf_we_n) |-> (we_lo_cnt == 8'(T_LO))); // R11
endmodule

bind nand_opseq nand_opseq_chk #(.T_LO(T_LO)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done_ok(done_ok),
    .tmo_err(tmo_err), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .buf_we(buf_we)
);

// File: tb/tb_nand_opseq.sv
// Directed bench for nand_opseq with a behavioural flash and page buffer.
module tb_nand_opseq;
    localparam int T_LO = 2;
    localparam int T_HI = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr_word = '0, cmd_word = '0;
    logic        large_page = 1'b0, spare_sel = 1'b0;
    logic [15:0] blk_num = '0, wait_limit = 16'hFFFF;
    logic [5:0]  page_idx = '0;
    logic [11:0] col_addr = '0, byte_cnt = '0;
    logic        dreg_load = 1'b0;
    logic [7:0]  dreg_in = '0, dreg_out;
    logic        busy, done_ok, tmo_err;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_out, nf_dq_in;
    logic        nf_rb_n = 1'b1;
    logic [12:0] buf_addr;
    logic        buf_re, buf_we;
    logic [7:0]  buf_wdata, buf_rdata = '0;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    nand_opseq dut (.*);

    // Flash and buffer model state.
    logic [7:0] bmem [int];
    logic [7:0] log_b [64];
    logic       log_c [64];
    logic       log_a [64];
    int         log_cnt = 0, rd_idx = 0, busy_left = 0, busy_len = 0;
    logic [7:0] trig = 8'h00, rd_seed = 8'h00;
    logic       prev_we = 1'b1, prev_re = 1'b1;
    int         we_run = 0, hi_run = 0, bad_lo = 0, min_hi = 1000;
    logic       v_excl = 1'b0, v_ce = 1'b0, v_rdbusy = 1'b0;

    assign nf_dq_in = rd_seed + rd_idx[7:0];

    // Page buffer with one clock of read latency.
    always @(posedge clk) begin
        if (buf_re) buf_rdata <= bmem.exists(int'(buf_addr)) ? bmem[int'(buf_addr)] : 8'h00;
        if (buf_we) bmem[int'(buf_addr)] = buf_wdata;
    end

    // Flash model and bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (busy_left > 0) busy_left--;
        if (!prev_we && nf_we_n) begin
            if (log_cnt < 64) begin
                log_b[log_cnt] = nf_dq_out;
                log_c[log_cnt] = nf_cle;
                log_a[log_cnt] = nf_ale;
            end
            log_cnt++;
            if (nf_cle && nf_dq_out == trig && busy_len > 0) busy_left = busy_len;
        end
        if (!prev_re && nf_re_n) rd_idx++;
        if (!nf_we_n) begin
            if (prev_we && hi_run < min_hi && hi_run > 0) min_hi = hi_run;
            we_run++;
        end else begin
            if (!prev_we && we_run != T_LO) bad_lo++;
            we_run = 0;
        end
        if (nf_we_n && !nf_ce_n) hi_run++; else hi_run = 0;
        if (nf_ce_n) hi_run = 0;
        if ((nf_cle && nf_ale) || (!nf_we_n && !nf_re_n)) v_excl = 1'b1;
        if (nf_ce_n && (!nf_we_n || !nf_re_n)) v_ce = 1'b1;
        if (!nf_re_n && !nf_rb_n) v_rdbusy = 1'b1;
        nf_rb_n = (busy_left == 0);
        prev_we = nf_we_n;
        prev_re = nf_re_n;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        log_cnt = 0; rd_idx = 0; busy_len = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!busy && (done_ok || tmo_err)) break;
        end
    endtask

    task automatic check_log(string req, int i, logic [7:0] b, logic c, logic a);
        check(req, {23'd0, log_c[i], log_a[i], log_b[i]}, {23'd0, c, a, b});
    endtask

    task automatic t_reset();
        check("R12 ce idle", nf_ce_n, 1'b1);
        check("R12 busy idle", busy, 1'b0);
        check("R10 flags idle", {done_ok, tmo_err}, 2'b00);
        check("R13 strobes idle", {nf_we_n, nf_re_n}, 2'b11);
    endtask

    // ID-style read: command, user address, read 256 bytes (R2 R9 R6 R1).
    task automatic t_id_read();
        clear_model();
        @(negedge clk) begin dreg_load = 1'b1; dreg_in = 8'h20; end
        @(negedge clk) dreg_load = 1'b0;
        instr_word = 32'h0000_07B1; cmd_word = 32'h0000_0090;
        large_page = 1'b0; spare_sel = 1'b0; blk_num = '0; page_idx = '0;
        col_addr = '0; byte_cnt = 12'd256; rd_seed = 8'h05;
        pulse_start();
        wait_end();
        check("R1 id bytes", log_cnt, 2);
        check_log("R2 id cmd", 0, 8'h90, 1'b1, 1'b0);
        check_log("R9 user addr", 1, 8'h20, 1'b0, 1'b1);
        check("R6 id count", rd_idx, 256);
        check("R6 id first", bmem[0], 8'h05);
        check("R6 id last", bmem[255], 8'h04);
        check("R10 done", {done_ok, tmo_err}, 2'b10);
        check("R12 ce released", nf_ce_n, 1'b1);
    endtask

    // Large-page full read to an odd page (R3 R4 R5 R6 R7).
    task automatic t_large_read();
        clear_model();
        instr_word = 32'h0007_2651; cmd_word = 32'h0000_3000;
        large_page = 1'b1; blk_num = 16'h0155; page_idx = 6'h2B;
        col_addr = '0; byte_cnt = '0; rd_seed = 8'h40;
        trig = 8'h30; busy_len = 20; v_rdbusy = 1'b0;
        pulse_start();
        wait_end();
        check("R1 large bytes", log_cnt, 7);
        check_log("R2 read cmd", 0, 8'h00, 1'b1, 1'b0);
        check_log("R3 col lo", 1, 8'h00, 1'b0, 1'b1);
        check_log("R3 col hi", 2, 8'h00, 1'b0, 1'b1);
        check_log("R4 row0", 3, 8'h6B, 1'b0, 1'b1);
        check_log("R4 row1", 4, 8'h55, 1'b0, 1'b1);
        check_log("R4 row2", 5, 8'h00, 1'b0, 1'b1);
        check_log("R2 confirm", 6, 8'h30, 1'b1, 1'b0);
        check("R7 full length", rd_idx, 2112);
        check("R5 slot4 first", bmem.exists(4096) ? bmem[4096] : 8'hEE, 8'h40);
        check("R5 slot4 last", bmem.exists(4096 + 2111) ? bmem[4096 + 2111] : 8'hEE, 8'h7F);
        check("R7 no overrun", bmem.exists(4096 + 2112), 1'b0);
        check("R5 no underrun", bmem.exists(4095), 1'b0);
        check("R6 no read while busy", v_rdbusy, 1'b0);
    endtask

    // Small-page spare write, wait and status (R3 R4 R5 R6 R8).
    task automatic t_small_write();
        clear_model();
        for (int i = 0; i < 5; i++) bmem[3587 + i] = 8'hA0 + 8'(i);
        instr_word = 32'h0A92_8651; cmd_word = 32'h0000_1080;
        large_page = 1'b0; spare_sel = 1'b1; blk_num = 16'h00A2;
        page_idx = 6'h13; col_addr = 12'd3; byte_cnt = 12'd5;
        rd_seed = 8'hE0; trig = 8'h10; busy_len = 30;
        pulse_start();
        wait_end();
        check("R1 write bytes", log_cnt, 11);
        check_log("R2 write cmd", 0, 8'h80, 1'b1, 1'b0);
        check_log("R3 small col", 1, 8'h03, 1'b0, 1'b1);
        check_log("R4 small row0", 2, 8'h53, 1'b0, 1'b1);
        check_log("R4 small row1", 3, 8'h14, 1'b0, 1'b1);
        check_log("R4 small row2", 4, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++)
            check_log("R5 R6 write data", 5 + i, 8'hA0 + 8'(i), 1'b0, 1'b0);
        check_log("R2 program cmd", 10, 8'h10, 1'b1, 1'b0);
        check("R8 status", dreg_out, 8'hE0);
        check("R8 done", {done_ok, tmo_err}, 2'b10);
        spare_sel = 1'b0;
    endtask

    // All eight slots issue commands and the list stops after slot 7 (R1 R2).
    task automatic t_eight_slots();
        clear_model();
        instr_word = 32'h4321_4321; cmd_word = 32'hD4C3_B2A1;
        pulse_start();
        wait_end();
        check("R1 eight bytes", log_cnt, 8);
        check_log("R2 cmd3", 3, 8'hD4, 1'b1, 1'b0);
        check_log("R2 wrap slot4", 4, 8'hA1, 1'b1, 1'b0);
        check_log("R1 slot7", 7, 8'hD4, 1'b1, 1'b0);
    endtask

    // Reserved code ends the list (R1).
    task automatic t_reserved_end();
        clear_model();
        instr_word = 32'h0000_02C1; cmd_word = 32'h0000_2211;
        pulse_start();
        wait_end();
        check("R1 reserved stops", log_cnt, 1);
        check("R1 reserved done", done_ok, 1'b1);
    endtask

    // Busy line stuck past the wait limit (R10).
    task automatic t_timeout();
        clear_model();
        instr_word = 32'h0000_0392; cmd_word = 32'h0077_3000;
        trig = 8'h30; busy_len = 1000; wait_limit = 16'd50;
        pulse_start();
        wait_end();
        check("R10 timeout flags", {done_ok, tmo_err}, 2'b01);
        check("R10 later slot skipped", log_cnt, 1);
        check("R12 ce after timeout", nf_ce_n, 1'b1);
        wait_limit = 16'hFFFF;
        repeat (1100) @(negedge clk);
    endtask

    // Second start while busy must not replay the list (R12).
    task automatic t_start_busy();
        logic ce_seen;
        clear_model();
        instr_word = 32'h0000_07B1; cmd_word = 32'h0000_0090;
        byte_cnt = 12'd64; large_page = 1'b0; rd_seed = 8'h00;
        pulse_start();
        repeat (20) @(negedge clk);
        ce_seen = nf_ce_n;
        pulse_start();
        wait_end();
        repeat (10) @(negedge clk);
        check("R12 ce low while busy", ce_seen, 1'b0);
        check("R12 start ignored bytes", log_cnt, 2);
        check("R12 start ignored reads", rd_idx, 64);
        check("R12 still idle", busy, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_read();
        t_large_read();
        t_small_write();
        t_eight_slots();
        t_reserved_end();
        t_timeout();
        t_start_busy();
        check("R11 low width", bad_lo, 0);
        check("R11 high width", (min_hi >= T_HI), 1'b1);
        check("R13 exclusivity", v_excl, 1'b0);
        check("R12 strobe without ce", v_ce, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule